// File: doc/BRIEF.md
# TCP Keep-Alive Scheduler

This block decides, for one socket, the clock cycle in which a keep-alive probe should be sent to the peer. It watches the socket's protocol mode, a flag that says the connection is established, and a one-cycle pulse for every data transfer in either direction. From these it raises a single-cycle request to the packet engine. The engine builds and sends the probe. Retransmission and detection of a dead peer belong to other logic.

Timing comes from an 8-bit interval value set by the host. The value counts in units of one prescaler period, which is five seconds at the default clock. A non-zero interval gives automatic probes each time the interval expires. A zero interval turns the automatic path off. In that case the host asks for each probe itself with a manual command, and that command is ignored whenever the interval is non-zero. No probe of either kind can go out until the established connection has carried at least one transfer. Each transfer restarts the countdown, so probes only fill gaps in traffic.

Top module: `tcp_keepalive_timer`

## Requirements
- R1: The interval counts in whole prescaler periods of TICKS_PER_UNIT cycles. With interval N > 0, the automatic request is first high N*TICKS_PER_UNIT cycles after the clock edge that sampled the restarting event.
- R2: Requests are produced only while the mode input equals 4'h1 (TCP) and the established flag is high. Under any other mode code there are no requests, automatic or manual.
- R3: After establishment, no request is produced until at least one transfer pulse has been sampled.
- R4: With a non-zero interval, requests repeat every N*TICKS_PER_UNIT cycles without further transfers, and each request is high for exactly one cycle.
- R5: With a zero interval there are no automatic requests. A manual command sampled while armed produces a request in the following cycle.
- R6: A manual command has no effect while the interval is non-zero.
- R7: Every transfer pulse restarts the countdown. A transfer sampled in the same cycle that a countdown would expire suppresses that request.
- R8: Dropping the established flag disarms the block and stops the countdown. A new transfer is needed after re-establishment before any request.
- R9: During and right after reset the request output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sock_mode | input | 4 | Socket protocol code, 4'h1 = TCP |
| estab | input | 1 | Connection established flag |
| xfer_pulse | input | 1 | One-cycle pulse per data transfer, either direction |
| ka_interval | input | 8 | Keep-alive interval in prescaler units, 0 = manual mode |
| manual_ka | input | 1 | Host manual keep-alive command |
| ka_req | output | 1 | One-cycle request to send a keep-alive probe |

## Verification
The request is registered. A manual command therefore shows on the output one cycle after the edge that samples it. An automatic request shows exactly N*TICKS_PER_UNIT cycles after the edge that sampled the last transfer or the last request. The bench drives and samples every signal on falling edges. It counts falling edges from the first falling edge after the restarting edge and compares the count with the exact figure, so a request that is one cycle early or late is reported. Cases where a request must not happen are checked by watching the output over a window longer than the longest pending interval.

// File: rtl/kat_pkg.sv
package kat_pkg;
   typedef enum logic [3:0] {
      SMODE_OFF    = 4'h0,
      SMODE_TCP    = 4'h1,
      SMODE_UDP    = 4'h2,
      SMODE_IPRAW  = 4'h3,
      SMODE_ETHRAW = 4'h4,
      SMODE_PPP    = 4'h5
   } sock_mode_e;

   localparam int unsigned DEFAULT_TICKS = 625_000_000; // 5 s at 125 MHz
endpackage

// File: rtl/kat_arm.sv
// Remembers that the established connection has carried traffic.
module kat_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic xfer,
   output logic armed
);
   always_ff @(posedge clk) begin
      if (!rst_n)       armed <= 1'b0;
      else if (!active) armed <= 1'b0;
      else if (xfer)    armed <= 1'b1;
   end
endmodule

// File: rtl/kat_prescaler.sv
// Divides the clock down to one tick per interval unit.
module kat_prescaler #(
   parameter int unsigned TICKS = 625_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   localparam int unsigned CW   = (TICKS > 1) ? $clog2(TICKS) : 1;
   localparam bit          POW2 = ((TICKS & (TICKS - 1)) == 0);
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   logic [CW-1:0] cnt;

   if (TICKS < 2) begin : g_bad
      $error("kat_prescaler: TICKS must be at least 2");
   end

   if (POW2) begin : g_wrap
      // power of two: natural roll-over, all-ones marks the last cycle
      assign tick = run && (&cnt);
      always_ff @(posedge clk) begin
         if (!rst_n)              cnt <= '0;
         else if (!run || restart) cnt <= '0;
         else                     cnt <= cnt + 1'b1;
      end
   end else begin : g_cmp
      assign tick = run && (cnt == LAST);
      always_ff @(posedge clk) begin
         if (!rst_n)              cnt <= '0;
         else if (!run || restart) cnt <= '0;
         else if (cnt == LAST)    cnt <= '0;
         else                     cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/kat_units.sv
// Counts prescaler ticks against the programmed interval.
module kat_units #(
   parameter int unsigned IW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          restart,
   input  logic          tick,
   input  logic [IW-1:0] interval,
   output logic          due
);
   logic [IW-1:0] units;
   logic [IW:0]   next_units;

   if (IW < 1) begin : g_bad
      $error("kat_units: IW must be at least 1");
   end

   assign next_units = {1'b0, units} + 1'b1;
   // >= so that a lowered interval fires at once instead of wrapping
   assign due = tick && (next_units >= {1'b0, interval});

   always_ff @(posedge clk) begin
      if (!rst_n)               units <= '0;
      else if (!run || restart) units <= '0;
      else if (due)             units <= '0;
      else if (tick)            units <= next_units[IW-1:0];
   end
endmodule

// File: rtl/kat_req.sv
// Merges the automatic and manual paths into one registered request.
module kat_req (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_due,
   input  logic xfer,
   input  logic manual_ok,
   output logic req
);
   always_ff @(posedge clk) begin
      if (!rst_n) req <= 1'b0;
      else        req <= (auto_due && !xfer) || manual_ok;
   end
endmodule

// File: rtl/tcp_keepalive_timer.sv
module tcp_keepalive_timer #(
   parameter int unsigned TICKS_PER_UNIT = kat_pkg::DEFAULT_TICKS,
   parameter int unsigned IW             = 8,
   parameter int unsigned MW             = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [MW-1:0] sock_mode,
   input  logic          estab,
   input  logic          xfer_pulse,
   input  logic [IW-1:0] ka_interval,
   input  logic          manual_ka,
   output logic          ka_req
);
   import kat_pkg::*;

   localparam logic [MW-1:0] TCP_CODE = MW'(SMODE_TCP);

   if (MW < 3) begin : g_bad_mw
      $error("tcp_keepalive_timer: MW too narrow for mode codes");
   end

   logic active, armed, zero_ivl, run, tick, due, manual_ok;

   assign active    = (sock_mode == TCP_CODE) && estab;
   assign zero_ivl  = (ka_interval == '0);
   assign run       = armed && active && !zero_ivl;
   assign manual_ok = manual_ka && armed && active && zero_ivl;

   kat_arm u_arm (
      .clk(clk), .rst_n(rst_n), .active(active), .xfer(xfer_pulse), .armed(armed)
   );

   kat_prescaler #(.TICKS(TICKS_PER_UNIT)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(xfer_pulse), .tick(tick)
   );

   kat_units #(.IW(IW)) u_units (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(xfer_pulse),
      .tick(tick), .interval(ka_interval), .due(due)
   );

   kat_req u_req (
      .clk(clk), .rst_n(rst_n), .auto_due(due), .xfer(xfer_pulse),
      .manual_ok(manual_ok), .req(ka_req)
   );
endmodule

// File: rtl/kat_checker.sv
module kat_checker #(
   parameter int unsigned IW = 8,
   parameter int unsigned MW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [MW-1:0] sock_mode,
   input logic          estab,
   input logic          xfer_pulse,
   input logic [IW-1:0] ka_interval,
   input logic          manual_ka,
   input logic          ka_req,
   input logic          armed
);
   assert_tcp_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ka_req |-> ($past(sock_mode) == MW'(1) && $past(estab)));

   assert_needs_traffic_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ka_req |-> $past(armed));

   assert_zero_manual_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ka_req |-> ($past(ka_interval) != '0 || $past(manual_ka)));

   assert_xfer_suppresses_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(xfer_pulse && ka_interval != '0) |-> !ka_req);

   assert_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!estab) |-> !armed);
endmodule

bind tcp_keepalive_timer kat_checker #(.IW(IW), .MW(MW)) u_kat_chk (
   .clk(clk), .rst_n(rst_n), .sock_mode(sock_mode), .estab(estab),
   .xfer_pulse(xfer_pulse), .ka_interval(ka_interval), .manual_ka(manual_ka),
   .ka_req(ka_req), .armed(armed)
);

// File: tb/tcp_keepalive_timer_tb_top.sv
module tcp_keepalive_timer_tb_top;
   localparam int P = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] mode = 4'h0;
   logic       estab = 1'b0;
   logic       xfer = 1'b0;
   logic [7:0] ivl = 8'd0;
   logic       man = 1'b0;
   logic       req;
   int         n_chk = 0;
   int         n_err = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   tcp_keepalive_timer #(.TICKS_PER_UNIT(P)) dut_i (
      .clk(clk), .rst_n(rst_n), .sock_mode(mode), .estab(estab),
      .xfer_pulse(xfer), .ka_interval(ivl), .manual_ka(man), .ka_req(req)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic pulse_xfer();
      xfer = 1'b1;
      @(negedge clk);
      xfer = 1'b0;
   endtask

   task automatic pulse_man();
      man = 1'b1;
      @(negedge clk);
      man = 1'b0;
   endtask

   task automatic measure(output int m);
      m = 0;
      do begin
         @(negedge clk);
         m++;
      end while (!req && m < 400);
   endtask

   task automatic quiet_for(input int n, input string tag);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (req) seen++;
      end
      check(seen == 0, tag, seen, 0);
   endtask

   task automatic t_reset();
      check(req == 1'b0, "R9 reset", req, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req == 1'b0, "R9 after reset", req, 0);
   endtask

   task automatic t_no_traffic();
      mode = 4'h1; estab = 1'b1; ivl = 8'd2;
      quiet_for(40, "R3 no request before first transfer");
   endtask

   task automatic t_auto();
      int m;
      pulse_xfer();
      measure(m);
      check(m == 2*P, "R1 R4 first auto request", m, 2*P);
      @(negedge clk);
      check(req == 1'b0, "R4 one-cycle request", req, 0);
      measure(m);
      check(m == 2*P - 1, "R4 periodic request", m, 2*P - 1);
      @(negedge clk);
   endtask

   task automatic t_units();
      int m;
      ivl = 8'd1;
      pulse_xfer();
      measure(m);
      check(m == P, "R1 interval 1", m, P);
      @(negedge clk);
      ivl = 8'd3;
      pulse_xfer();
      measure(m);
      check(m == 3*P, "R1 interval 3", m, 3*P);
      @(negedge clk);
   endtask

   task automatic t_restart();
      int m;
      ivl = 8'd2;
      pulse_xfer();
      quiet_for(5, "R7 quiet before restart");
      pulse_xfer();
      measure(m);
      check(m == 2*P, "R7 restart on transfer", m, 2*P);
      @(negedge clk);
      // transfer sampled on the very edge the countdown expires
      ivl = 8'd1;
      pulse_xfer();
      repeat (P - 1) @(negedge clk);
      pulse_xfer();
      check(req == 1'b0, "R7 coincident transfer suppresses", req, 0);
      measure(m);
      check(m == P, "R7 countdown after suppression", m, P);
      @(negedge clk);
   endtask

   task automatic t_manual_ignored();
      int m;
      ivl = 8'd3;
      pulse_xfer();
      pulse_man();
      check(req == 1'b0, "R6 manual ignored", req, 0);
      measure(m);
      check(m == 3*P - 1, "R6 auto timing unchanged", m, 3*P - 1);
      @(negedge clk);
   endtask

   task automatic t_manual();
      ivl = 8'd0;
      pulse_xfer();
      quiet_for(30, "R5 no auto with zero interval");
      pulse_man();
      check(req == 1'b1, "R5 manual request", req, 1);
      @(negedge clk);
      check(req == 1'b0, "R5 manual request width", req, 0);
   endtask

   task automatic t_leave();
      int m;
      estab = 1'b0;
      repeat (2) @(negedge clk);
      estab = 1'b1;
      pulse_man();
      check(req == 1'b0, "R8 manual after re-establish without transfer", req, 0);
      ivl = 8'd1;
      quiet_for(30, "R8 countdown stopped");
      pulse_xfer();
      measure(m);
      check(m == P, "R8 re-armed by transfer", m, P);
      @(negedge clk);
   endtask

   task automatic t_other_mode();
      mode = 4'h2; ivl = 8'd1;
      pulse_xfer();
      quiet_for(30, "R2 no auto outside TCP");
      ivl = 8'd0;
      pulse_man();
      check(req == 1'b0, "R2 no manual outside TCP", req, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_no_traffic();
      t_auto();
      t_units();
      t_restart();
      t_manual_ignored();
      t_manual();
      t_leave();
      t_other_mode();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule